// File: doc/BRIEF.md
# Dual-Path Real-to-Complex Down Converter

This block takes a single stream of real signed 16-bit samples and turns it into two independent complex baseband streams. Each path owns a numerically controlled oscillator, whose frequency is set by writing a 32-bit phase step into that path's tuning register. The oscillator's cosine and sine multiply the real sample to form I and Q. A fixed low-pass FIR then filters the result, and the path keeps one sample out of every eight. Tune each oscillator so that the wanted intermediate frequency lands at zero; the two paths can sit on different carriers of the same input.

The two paths share one decimation counter, so their outputs appear together under a single strobe. A synchronous reset clears the oscillator phases, the filter histories, the tuning words and the decimation counter. Both paths therefore restart from a common phase reference. The usable band of each output is about 80% of the output sample rate.

Top module: `ddc_dual_path`

## Requirements
- R1: Each path has its own 32-bit tuning word. A cycle with `cfg_we` high loads `cfg_inc` into the path selected by `cfg_path` (0 or 1) and leaves the other path's word unchanged.
- R2: Each oscillator phase starts at 0 after reset and advances by its tuning word on every cycle with `in_valid` high. Sample n (counted from reset) therefore meets phase n·step mod 2^32. Cosine and sine come from a quarter-wave table addressed by the top phase bits. Phase 0 gives cos 32767 and sin 0, a quarter turn gives cos 0 and sin 32767, and a half turn gives cos −32767 and sin 0.
- R3: The mixer forms I = round(x·cos / 2^15) and Q = round(−x·sin / 2^15). Rounding adds 2^14 and then shifts right arithmetically. The result saturates to the signed 16-bit range.
- R4: A negative tuning frequency is written as the two's-complement step. A step of 0xC0000000 turns the sine the opposite way from 0x40000000, so for the same input Q comes out with the opposite sign.
- R5: Each decimation filter is a 16-tap symmetric FIR with coefficients that sum to 4096 (12 fractional bits), which gives unity DC gain. Its even-indexed taps and its odd-indexed taps each sum to 2048, so a period-2 mixed sequence a,b settles to (2048a + 2048b + 2048) >> 12. The output is rounded and saturated to 16 bits.
- R6: Exactly one output is produced for every 8 accepted samples. Cycles with `in_valid` low are not counted. `out_valid` is a one-cycle pulse that is high during the second cycle after the clock edge that accepts the 8th sample.
- R7: `out_i` and `out_q` change only at the edge that raises `out_valid`, and they hold between pulses.
- R8: While `rst_n` is low, the next edge clears `out_valid`, `out_i`, `out_q`, the oscillator phases, the filter histories, the decimation counter and both tuning words (a tuning word of 0 leaves the input unshifted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Tuning word write strobe |
| cfg_path | input | 1 | Path selected by a tuning write |
| cfg_inc | input | 32 | Phase step per input sample |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Real signed input sample |
| out_valid | output | 1 | Decimated output strobe |
| out_i | output | 2x16 | In-phase output per path, path 0 in the low slice |
| out_q | output | 2x16 | Quadrature output per path, path 0 in the low slice |

## Verification
The strobe properties assume that `in_valid` is a clean level sampled once per clock and that reset is held for at least one edge. The stimulus drives every input at the falling edge and holds reset for three cycles before each case. Tuning words are loaded only after reset has been released and before the first sample is streamed, so each case starts from phase zero. The stimulus uses the step values 0, a quarter turn, a half turn and the negative quarter turn. With these steps the oscillator takes only exact table values, and once the filter history is full the outputs become constant or period-2 sequences whose settled values follow arithmetically.

// File: rtl/ddc_pkg.sv
// Shared widths, sample type, rounding helper and the fixed filter taps
// for the dual-path down converter. Assumes a 16-tap symmetric filter.
package ddc_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int PHASE_W   = 32;
    localparam int LUT_BITS  = 6;
    localparam int NTAPS     = 16;
    localparam int HALF_TAPS = NTAPS / 2;
    localparam int COEF_W    = 12;
    localparam int COEF_FRAC = 12;
    localparam int DECIM     = 8;
    localparam int CNT_W     = $clog2(DECIM);
    localparam int ACC_W     = 48;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    localparam logic signed [ACC_W-1:0] ACC_HI = (ACC_W'(1) <<< (SAMPLE_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_HI - ACC_W'(1);

    // Round half up by 'sh' bits, then clamp to the signed sample range.
    function automatic sample_t round_sat(input logic signed [ACC_W-1:0] v, input int sh);
        logic signed [ACC_W-1:0] half;
        logic signed [ACC_W-1:0] t;
        half = '0;
        half[sh-1] = 1'b1;
        t = (v + half) >>> sh;
        if (t > ACC_HI)      return ACC_HI[SAMPLE_W-1:0];
        else if (t < ACC_LO) return ACC_LO[SAMPLE_W-1:0];
        else                 return t[SAMPLE_W-1:0];
    endfunction

    // Unique half of the symmetric low-pass taps; total sum is 2^COEF_FRAC.
    function automatic logic signed [COEF_W-1:0] tap_coef(input int k);
        case (k)
            0:       return 12'sd40;
            1:       return 12'sd90;
            2:       return 12'sd160;
            3:       return 12'sd240;
            4:       return 12'sd320;
            5:       return 12'sd380;
            6:       return 12'sd400;
            7:       return 12'sd418;
            default: return 12'sd0;
        endcase
    endfunction
endpackage

// File: rtl/ddc_nco.sv
// Phase-accumulating oscillator with quarter-wave sine table.
// Assumes 'step' pulses once per accepted input sample; outputs are
// combinational from the current phase (phase used by this sample).
module ddc_nco
    import ddc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [PHASE_W-1:0] inc,
    output sample_t            cos_o,
    output sample_t            sin_o
);
    localparam int LUT_N = 1 << LUT_BITS;

    // Build the quarter-wave magnitude table, LUT_N+1 points from 0 to pi/2.
    function automatic logic [LUT_N:0][SAMPLE_W-1:0] build_lut();
        logic [LUT_N:0][SAMPLE_W-1:0] t;
        real ang;
        for (int i = 0; i <= LUT_N; i++) begin
            ang  = 3.141592653589793 * real'(i) / (2.0 * real'(LUT_N));
            t[i] = SAMPLE_W'($rtoi(32767.0 * $sin(ang) + 0.5));
        end
        return t;
    endfunction

    localparam logic [LUT_N:0][SAMPLE_W-1:0] QLUT = build_lut();

    // Sine of a phase given as quadrant plus table index.
    function automatic sample_t quad_sin(input logic [1:0] quad, input logic [LUT_BITS-1:0] idx);
        int      j;
        sample_t mag;
        j   = quad[0] ? (LUT_N - int'(idx)) : int'(idx);
        mag = QLUT[j];
        return quad[1] ? -mag : mag;
    endfunction

    logic [PHASE_W-1:0]  phase_q;
    logic [1:0]          quad;
    logic [LUT_BITS-1:0] idx;

    // Phase register: cleared by reset, advanced once per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (step) phase_q <= phase_q + inc;
    end

    assign quad  = phase_q[PHASE_W-1 -: 2];
    assign idx   = phase_q[PHASE_W-3 -: LUT_BITS];
    assign sin_o = quad_sin(quad, idx);
    assign cos_o = quad_sin(quad + 2'd1, idx);
endmodule

// File: rtl/ddc_mixer.sv
// Half complex mixer: real sample times cosine and negated sine.
// Purely combinational; products are rounded and saturated to 16 bits.
module ddc_mixer
    import ddc_pkg::*;
(
    input  sample_t x,
    input  sample_t c,
    input  sample_t s,
    output sample_t mix_i,
    output sample_t mix_q
);
    logic signed [ACC_W-1:0] prod_i;
    logic signed [ACC_W-1:0] prod_q;

    // Full-precision products in the wide accumulator width.
    assign prod_i = ACC_W'(x) * ACC_W'(c);
    assign prod_q = ACC_W'(x) * (-ACC_W'(s));

    assign mix_i = round_sat(prod_i, SAMPLE_W - 1);
    assign mix_q = round_sat(prod_q, SAMPLE_W - 1);
endmodule

// File: rtl/ddc_decim_fir.sv
// Symmetric low-pass FIR evaluated only on decimated output cycles.
// Assumes 'shift_en' marks each accepted sample and 'eval' comes after
// the last sample of a decimation group has entered the delay line.
module ddc_decim_fir
    import ddc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    shift_en,
    input  sample_t din,
    input  logic    eval,
    output sample_t dout
);
    sample_t                 dl [NTAPS];
    logic signed [ACC_W-1:0] acc;

    // Delay line: cleared by reset, shifts in one mixed sample per accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) dl[k] <= '0;
        end else if (shift_en) begin
            dl[0] <= din;
            for (int k = 1; k < NTAPS; k++) dl[k] <= dl[k-1];
        end
    end

    // Folded multiply-accumulate over mirrored tap pairs.
    always_comb begin
        acc = '0;
        for (int k = 0; k < HALF_TAPS; k++)
            acc += (ACC_W'(dl[k]) + ACC_W'(dl[NTAPS-1-k])) * ACC_W'(tap_coef(k));
    end

    // Output register: loads the rounded sum only on evaluation cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (eval) dout <= round_sat(acc, COEF_FRAC);
    end
endmodule

// File: rtl/ddc_dual_path.sv
// Top of the dual-path down converter. One real input feeds NPATH
// oscillator/mixer/filter paths; a shared counter selects every DECIM-th
// accepted sample. Assumes in_valid is a synchronous level.
module ddc_dual_path
    import ddc_pkg::*;
#(
    parameter  int NPATH = 2,
    localparam int SEL_W = (NPATH > 1) ? $clog2(NPATH) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [SEL_W-1:0]                 cfg_path,
    input  logic [PHASE_W-1:0]               cfg_inc,
    input  logic                             in_valid,
    input  logic [SAMPLE_W-1:0]              in_sample,
    output logic                             out_valid,
    output logic [NPATH-1:0][SAMPLE_W-1:0]   out_i,
    output logic [NPATH-1:0][SAMPLE_W-1:0]   out_q
);
    localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(DECIM - 1);

    logic [CNT_W-1:0] ph_cnt;
    logic             eval_q;
    sample_t          x_in;

    assign x_in = in_sample;

    // Decimation phase: counts accepted samples modulo DECIM.
    always_ff @(posedge clk) begin
        if (!rst_n)        ph_cnt <= '0;
        else if (in_valid) ph_cnt <= (ph_cnt == LAST_PH) ? '0 : ph_cnt + 1'b1;
    end

    // Evaluation flag one cycle after the group's last sample, then strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eval_q    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            eval_q    <= in_valid && (ph_cnt == LAST_PH);
            out_valid <= eval_q;
        end
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        logic [PHASE_W-1:0] inc_q;
        sample_t            nco_c, nco_s, mx_i, mx_q, fy_i, fy_q;

        // Tuning word register for this path.
        always_ff @(posedge clk) begin
            if (!rst_n)                                     inc_q <= '0;
            else if (cfg_we && (cfg_path == SEL_W'(p)))     inc_q <= cfg_inc;
        end

        ddc_nco u_nco (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (in_valid),
            .inc   (inc_q),
            .cos_o (nco_c),
            .sin_o (nco_s)
        );

        ddc_mixer u_mix (
            .x     (x_in),
            .c     (nco_c),
            .s     (nco_s),
            .mix_i (mx_i),
            .mix_q (mx_q)
        );

        ddc_decim_fir u_fir_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (in_valid),
            .din      (mx_i),
            .eval     (eval_q),
            .dout     (fy_i)
        );

        ddc_decim_fir u_fir_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (in_valid),
            .din      (mx_q),
            .eval     (eval_q),
            .dout     (fy_q)
        );

        assign out_i[p] = fy_i;
        assign out_q[p] = fy_q;
    end
endmodule

// File: rtl/ddc_dual_path_chk.sv
// Property checker for the dual-path down converter, bound to the top.
// Keeps its own modulo-DECIM count of accepted samples.
module ddc_dual_path_chk
    import ddc_pkg::*;
#(
    parameter int NPATH = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic                           out_valid,
    input logic [NPATH-1:0][SAMPLE_W-1:0] out_i,
    input logic [NPATH-1:0][SAMPLE_W-1:0] out_q
);
    logic [CNT_W-1:0] seen;

    // Independent count of accepted samples within a decimation group.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen <= '0;
        else if (in_valid) seen <= (seen == CNT_W'(DECIM - 1)) ? '0 : seen + 1'b1;
    end

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6
    strobe_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seen == CNT_W'(DECIM - 1)) |=> ##1 out_valid);

    // R6
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && seen == CNT_W'(DECIM - 1), 2));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind ddc_dual_path ddc_dual_path_chk #(.NPATH(NPATH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/ddc_dual_path_bench.sv
`timescale 1ns/1ps
module ddc_dual_path_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [0:0]        cfg_path = 1'b0;
    logic [31:0]       cfg_inc = '0;
    logic              in_valid = 1'b0;
    logic [15:0]       in_sample = '0;
    logic              out_valid;
    logic [1:0][15:0]  out_i;
    logic [1:0][15:0]  out_q;

    int total = 0;
    int bad = 0;
    int nstrobe = 0;
    logic signed [15:0] last_i [2];
    logic signed [15:0] last_q [2];

    always #2.5 clk = ~clk;

    ddc_dual_path u_ddc_dual_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_path  (cfg_path),
        .cfg_inc   (cfg_inc),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    // Monitor: capture every strobe at the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            nstrobe = nstrobe + 1;
            for (int p = 0; p < 2; p++) begin
                last_i[p] = out_i[p];
                last_q[p] = out_q[p];
            end
        end
    end

    function automatic longint mix_of(longint v);
        return (v * 32767 + 16384) >>> 15;
    endfunction

    function automatic longint pair_avg(longint a, longint b);
        return (a * 2048 + b * 2048 + 2048) >>> 12;
    endfunction

    function automatic logic [15:0] sample_of(int pat, int x, int k);
        case (pat)
            0:       return 16'(x);
            1:       return (k % 2 == 0) ? 16'(x) : 16'(-x);
            default: return (k % 4 == 1) ? 16'(x) : ((k % 4 == 3) ? 16'(-x) : 16'd0);
        endcase
    endfunction

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nstrobe = 0;
    endtask

    task automatic write_inc(int p, logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_path = 1'(p);
        cfg_inc = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic stream(int pat, int x, int n, bit gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sample = sample_of(pat, x, k);
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_case(string tag, int pat, int x, bit tune, logic [31:0] i0, logic [31:0] i1,
                            longint e0i, longint e0q, longint e1i, longint e1q, int n, bit gap);
        reset_dut();
        if (tune) begin
            write_inc(0, i0);
            write_inc(1, i1);
        end
        stream(pat, x, n, gap);
        chk({"R6 strobe count ", tag}, nstrobe, n / 8);
        chk({tag, " path0 I"}, last_i[0], e0i);
        chk({tag, " path0 Q"}, last_q[0], e0q);
        chk({tag, " path1 I"}, last_i[1], e1i);
        chk({tag, " path1 Q"}, last_q[1], e1q);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        // R8: reset state seen at the ports
        repeat (2) @(negedge clk);
        chk("R8 reset out_valid", out_valid, 0);
        chk("R8 reset out_i", out_i, 0);
        chk("R8 reset out_q", out_q, 0);

        // R2 R3 R5: DC input, path0 unshifted, path1 half turn cancels in filter
        for (int t = 0; t < 3; t++) begin
            int x;
            x = (t == 0) ? 1000 : ((t == 1) ? -32768 : 32767);
            run_case("R2 R3 R5 dc", 0, x, 1'b1, 32'h0, 32'h8000_0000,
                     mix_of(x), 0, pair_avg(mix_of(x), mix_of(-x)), 0, 64, 1'b0);
        end

        // R1 R2 R5: alternating input, the half-turn path brings it to zero IF
        run_case("R1 R2 R5 alt", 1, 12345, 1'b1, 32'h0, 32'h8000_0000,
                 pair_avg(mix_of(12345), mix_of(-12345)), 0, mix_of(12345), 0, 64, 1'b0);

        // R4 R3: sine at a quarter of the rate, positive versus negative tuning
        run_case("R4 R3 sine", 2, 20000, 1'b1, 32'h4000_0000, 32'hC000_0000,
                 0, pair_avg(0, mix_of(-20000)), 0, pair_avg(0, mix_of(20000)), 64, 1'b0);
        run_case("R4 R3 sine neg", 2, -7777, 1'b1, 32'h4000_0000, 32'hC000_0000,
                 0, pair_avg(0, mix_of(7777)), 0, pair_avg(0, mix_of(-7777)), 64, 1'b0);

        // R6: idle cycles between samples are not counted
        run_case("R6 gaps", 0, 500, 1'b1, 32'h0, 32'h8000_0000,
                 mix_of(500), 0, pair_avg(mix_of(500), mix_of(-500)), 0, 48, 1'b1);

        // R8: odd-length run leaves phase at a half turn; the next reset must clear it
        run_case("R8 odd run", 1, 3000, 1'b1, 32'h0, 32'h8000_0000,
                 pair_avg(mix_of(3000), mix_of(-3000)), 0, mix_of(3000), 0, 37, 1'b0);
        run_case("R8 phase cleared", 1, 3000, 1'b1, 32'h0, 32'h8000_0000,
                 pair_avg(mix_of(3000), mix_of(-3000)), 0, mix_of(3000), 0, 64, 1'b0);

        // R8: tuning words cleared by reset (no write, path1 then passes DC)
        run_case("R8 tuning cleared", 0, 4000, 1'b0, 32'h0, 32'h0,
                 mix_of(4000), 0, mix_of(4000), 0, 64, 1'b0);

        // R8 R7: reset in the middle of a stream clears outputs and strobe
        reset_dut();
        write_inc(0, 32'h0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sample = 16'd9000;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 held value after stream", last_i[0], out_i[0]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid reset out_valid", out_valid, 0);
        chk("R8 mid reset out_i", out_i, 0);
        rst_n = 1'b1;

        finish_up();
    end
endmodule